// File: doc/BRIEF.md
# IR Remote Carrier Generator

This block produces the modulation carrier used by an infrared remote transmitter. It shares a single output pin with a plain one-bit level output. The system clock is first slowed by a fixed prescaler of four. A programmable divider then divides the result by m·2^n, where m is 2 or 3 and n is 0 to 3. The high part of each carrier period is either one half or one third of the period.

Static configuration inputs choose carrier or level operation and set m, n and the duty. A software-writable data bit controls the pin. In carrier mode the bit is an active-low gate: 0 runs the carrier and 1 silences it, with the pin held low. In level mode the bit is latched and driven straight to the pin. The bit can be read back at any time, so that read-modify-write sequences work.

Top module: `irc_carrier_gen`

## Requirements
- R1: While the carrier runs, the divider phase advances exactly once every 4 `clk` cycles. Each carrier period therefore lasts 4·ratio `clk` cycles.
- R2: The ratio is m·2^n. `cfg_m3`=0 selects m=2 and `cfg_m3`=1 selects m=3. `cfg_n` (0..3) is n. The legal ratios are 2, 4, 8, 16, 3, 6, 12 and 24.
- R3: With m=2, the pin is high for ratio/2 prescaled cycles of each period, whatever `cfg_third_duty` is.
- R4: With m=3 and n>0, `cfg_third_duty`=1 gives ratio/3 high cycles per period and `cfg_third_duty`=0 gives ratio/2.
- R5: With m=3 and n=0 (ratio 3), the high time is always 1 prescaled cycle (1/3 duty), even when `cfg_third_duty`=0.
- R6: Each period starts with its high part. Writing 0 to the data bit in carrier mode (`cfg_carrier_mode`=1) starts a fresh, full-width period: the pin is high from the first `clk` cycle after the write edge.
- R7: In carrier mode, writing 1 to the data bit forces the pin low from the first cycle after the write edge. The pin then stays low until the bit is written with 0.
- R8: In level mode (`cfg_carrier_mode`=0), the pin equals the latched data bit. The bit keeps its value until the next write.
- R9: After reset the data bit is 1. The pin is therefore low in carrier mode and high in level mode.
- R10: `rd_data` returns the current data bit, which is updated on the edge where `wr_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_carrier_mode | input | 1 | 1: carrier output, 0: level output (static) |
| cfg_m3 | input | 1 | Odd factor select: 0 gives m=2, 1 gives m=3 (static) |
| cfg_n | input | 2 | Power-of-two exponent n (static) |
| cfg_third_duty | input | 1 | Request 1/3 duty; honoured only when m=3 (static) |
| wr_en | input | 1 | Write strobe for the data bit |
| wr_data | input | 1 | Value written to the data bit |
| rd_data | output | 1 | Read-back of the data bit |
| pin_out | output | 1 | Shared carrier / level output |

## Verification
The carrier is swept over all sixteen combinations of m, n and the duty request. Each combination is compared cycle by cycle against a waveform worked out arithmetically over two full periods. This tells apart errors in the ratio, in the prescale rate, in the high-time rule and in the forced one-third duty at ratio 3. Each combination is started from a gating write, which exposes any stale phase left over from the previous run. It is then stopped with a disabling write, which checks the forced-low hold. Level mode is tried with alternating writes and with idle stretches under changing configuration, which tells the latch behaviour apart from the carrier path.

// File: rtl/irc_pkg.sv
package irc_pkg;

    typedef enum logic {
        PIN_LEVEL   = 1'b0,
        PIN_CARRIER = 1'b1
    } pin_mode_e;

endpackage

// File: rtl/irc_prescale.sv
module irc_prescale #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = run && (st_q.cnt == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1

endmodule

// File: rtl/irc_cfg_decode.sv
module irc_cfg_decode #(
    parameter int N_W     = 2,
    parameter int RATIO_W = 5
) (
    input  logic               m3,
    input  logic [N_W-1:0]     n,
    input  logic               third_req,
    output logic [RATIO_W-1:0] ratio,
    output logic [RATIO_W-1:0] high_len
);
    logic third_eff;
    logic [RATIO_W-1:0] base;

    always_comb begin
        base      = m3 ? RATIO_W'(3) : RATIO_W'(2);
        ratio     = base << n;
        third_eff = m3 && ((n == '0) || third_req);
        if (third_eff) begin
            high_len = RATIO_W'(1) << n;
        end else begin
            high_len = ratio >> 1;
        end
    end

endmodule

// File: rtl/irc_divider.sv
module irc_divider #(
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               tick,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RATIO_W-1:0] high_len,
    output logic               carrier
);
    typedef struct packed {
        logic [RATIO_W-1:0] phase;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.phase = '0;
        end else if (tick) begin
            if (st_q.phase == ratio - RATIO_W'(1)) st_d.phase = '0;
            else                                   st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carrier = run && (st_q.phase < high_len);

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase < ratio); // R2
    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.phase == '0)); // R6
    AST_PHASE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(st_q.phase)); // R1

endmodule

// File: rtl/irc_carrier_gen.sv
module irc_carrier_gen #(
    parameter int PRE_DIV = 4,
    parameter int N_W     = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_carrier_mode,
    input  logic           cfg_m3,
    input  logic [N_W-1:0] cfg_n,
    input  logic           cfg_third_duty,
    input  logic           wr_en,
    input  logic           wr_data,
    output logic           rd_data,
    output logic           pin_out
);
    import irc_pkg::*;

    localparam int N_MAX   = (1 << N_W) - 1;
    localparam int RATIO_W = $clog2((3 << N_MAX) + 1);

    typedef struct packed {
        logic data;
    } top_state_t;

    top_state_t st_d, st_q;
    pin_mode_e mode;
    logic run, tick, carrier;
    logic [RATIO_W-1:0] ratio, high_len;

    assign mode = pin_mode_e'(cfg_carrier_mode);

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.data = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{data: 1'b1};
        else        st_q <= st_d;
    end

    assign run = (mode == PIN_CARRIER) && !st_q.data;

    irc_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk (clk),
        .rst_n(rst_n),
        .run (run),
        .tick(tick)
    );

    irc_cfg_decode #(.N_W(N_W), .RATIO_W(RATIO_W)) u_dec (
        .m3       (cfg_m3),
        .n        (cfg_n),
        .third_req(cfg_third_duty),
        .ratio    (ratio),
        .high_len (high_len)
    );

    irc_divider #(.RATIO_W(RATIO_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .ratio   (ratio),
        .high_len(high_len),
        .carrier (carrier)
    );

    assign pin_out = (mode == PIN_CARRIER) ? carrier : st_q.data;
    assign rd_data = st_q.data;

    AST_GATE_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_carrier_mode && wr_en && wr_data) |=> !pin_out); // R7
    AST_ENABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_carrier_mode && wr_en && !wr_data && rd_data) |=> pin_out); // R6
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_carrier_mode && wr_en) |=> (pin_out == $past(wr_data))); // R8
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_carrier_mode && !wr_en) |=> $stable(pin_out)); // R8
    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data))); // R10

endmodule

// File: tb/sim_irc_carrier_gen.sv
module sim_irc_carrier_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_carrier_mode = 1'b1;
    logic cfg_m3 = 1'b0;
    logic [1:0] cfg_n = 2'd0;
    logic cfg_third_duty = 1'b0;
    logic wr_en = 1'b0;
    logic wr_data = 1'b0;
    logic rd_data, pin_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    irc_carrier_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_carrier_mode(cfg_carrier_mode),
        .cfg_m3(cfg_m3), .cfg_n(cfg_n), .cfg_third_duty(cfg_third_duty),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pin_out(pin_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive a write at a negedge; returns at the next negedge (first sample point)
    task automatic write_bit(input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_carrier(input logic m3, input int n, input logic third);
        int ratio, high, bad_at, bad_act, bad_exp;
        string tag;
        cfg_m3 = m3; cfg_n = 2'(n); cfg_third_duty = third;
        ratio = (m3 ? 3 : 2) << n;
        if (m3 && (n == 0 || third)) high = ratio / 3;
        else high = ratio / 2;
        if (!m3) tag = "R3/R1/R2";
        else if (n == 0) tag = "R5/R1/R2";
        else tag = "R4/R1/R2";
        write_bit(1'b0);
        check("R6 first cycle high", int'(pin_out), 1);
        bad_at = -1; bad_act = 0; bad_exp = 0;
        for (int k = 0; k < 8 * ratio; k++) begin
            int exp_v;
            exp_v = (((k / 4) % ratio) < high) ? 1 : 0;
            if (bad_at < 0 && int'(pin_out) != exp_v) begin
                bad_at = k; bad_act = int'(pin_out); bad_exp = exp_v;
            end
            @(negedge clk);
        end
        check($sformatf("%s waveform m3=%0d n=%0d third=%0d first_bad=%0d",
              tag, m3, n, third, bad_at), bad_act, bad_exp);
        write_bit(1'b1);
        begin
            int highs = 0;
            for (int k = 0; k < 12; k++) begin
                highs += int'(pin_out);
                @(negedge clk);
            end
            check("R7 disabled pin stays low", highs, 0);
        end
        check("R10 readback after disable", int'(rd_data), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R9 data bit reset", int'(rd_data), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset pin low in carrier mode", int'(pin_out), 0);
        check("R9 data bit after reset", int'(rd_data), 1);
        repeat (20) @(negedge clk);
        check("R9 carrier idle after reset", int'(pin_out), 0);

        for (int m = 0; m < 2; m++)
            for (int n = 0; n < 4; n++)
                for (int t = 0; t < 2; t++)
                    run_carrier(1'(m), n, 1'(t));

        // level mode
        cfg_carrier_mode = 1'b0;
        @(negedge clk);
        check("R8 level shows bit=1", int'(pin_out), 1);
        write_bit(1'b0);
        check("R8 level write 0", int'(pin_out), 0);
        check("R10 readback 0", int'(rd_data), 0);
        cfg_m3 = 1'b1; cfg_n = 2'd2; cfg_third_duty = 1'b0;
        begin
            int highs = 0;
            for (int k = 0; k < 40; k++) begin
                highs += int'(pin_out);
                @(negedge clk);
            end
            check("R8 level holds 0, no carrier", highs, 0);
        end
        write_bit(1'b1);
        check("R8 level write 1", int'(pin_out), 1);
        check("R10 readback 1", int'(rd_data), 1);
        begin
            int lows = 0;
            for (int k = 0; k < 40; k++) begin
                lows += 1 - int'(pin_out);
                @(negedge clk);
            end
            check("R8 level holds 1", lows, 0);
        end

        // reset in level mode with the bit cleared
        write_bit(1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset pin high in level mode", int'(pin_out), 1);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule